// File: doc/BRIEF.md
# Memory-Cycle Steal Arbiter

This block sits between an I/O channel and the storage-cycle sequencer of a character-serial processor. It decides, once per memory cycle, whether the next storage cycle continues the processor's own work or goes to an I/O character transfer. The sequencer supplies a ring of one-hot phase strobes. At the decision phase the arbiter fixes its choice. At the branch phase it raises either the processor-continue strobe or the I/O-cycle strobe.

Four independent channel request lines are merged into one request, and all four pass through the same qualification. To keep a late request from racing the branch decision, the merged request is sampled only at the end-of-cycle phase. A request that rises at any other point, including while the processor-continue strobe is up, waits for the next end-of-cycle phase. In overlapped mode a device may not take two storage cycles in a row. In non-overlapped mode, or when a high-rate device forces it, consecutive cycles may be granted. A consistency monitor sets a sticky instruction-check flag whenever the error-sample strobe sees the processor-continue strobe together with a live qualified request.

Top module: `cyc_steal_arb`

## Requirements
- R1: The merged request is the OR of all `src_req_i` bits; if any bit is high in a clock whose phase vector has only bit `NPH-1` (end-of-cycle) set, `xfer_req_o` may rise from the next clock, and the I/O strobe follows in the next memory cycle.
- R2: The merged request is sampled only at the end-of-cycle phase. A source pulse confined to any other phase, including the branch phase while `gate_a_o` is high, never produces an I/O cycle.
- R3: In a clock with only bit 1 (branch) of `phase_i` set, exactly one of `gate_a_o` and `gate_r_o` is high. `gate_r_o` is chosen exactly when `xfer_req_o` was high in the last clock with only bit 0 (decision) set. In every other clock both are low.
- R4: `xfer_req_o` equals the sampled request, except that it is forced low while effective-overlapped mode holds (`ovl_i`=1 and `burst_i`=0) and the most recent branch phase selected the I/O cycle.
- R5: In effective-overlapped mode, a request held continuously is granted in alternate memory cycles only: 6 grants in 12 cycles, starting from idle.
- R6: With `ovl_i`=0, or with `burst_i`=1, a request held continuously is granted in every memory cycle.
- R7: `inst_chk_o` rises one clock after a clock in which `err_smp_i`, `gate_a_o` and `xfer_req_o` are all high, and it stays high until reset.
- R8: A synchronous active-low reset clears the sampled request, the decision, the cycle history and `inst_chk_o`. The first branch phase after reset selects `gate_a_o`.
- R9: A clock whose phase vector is not one-hot (all zero, or two bits set) has no effect: nothing is sampled, no decision is taken, and both branch strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | NSRC | Channel request sources, level |
| phase_i | input | NPH | One-hot phase strobes; bit 0 decision, bit 1 branch, bit NPH-1 end-of-cycle |
| err_smp_i | input | 1 | Error-sample strobe for the consistency monitor |
| ovl_i | input | 1 | Overlapped mode requested |
| burst_i | input | 1 | High-rate device; forces non-overlapped behaviour |
| xfer_req_o | output | 1 | Qualified transfer-cycle request |
| gate_a_o | output | 1 | Processor-continue strobe at the branch phase |
| gate_r_o | output | 1 | I/O-cycle strobe at the branch phase |
| inst_chk_o | output | 1 | Sticky instruction-check flag |

## Verification
The hardest situation to reach from the ports is the one the monitor exists for: the processor-continue strobe coinciding with a live qualified request. A correct arbiter keeps its decision and its request consistent within a memory cycle. The stimulus therefore first earns an I/O grant in overlapped mode, so that the next cycle is blocked. It then drops the overlapped flag between the decision and branch phases, which revives the request after the choice for the processor has been made. A separate sweep places a one-clock source pulse at every phase offset, rotating through the four sources, and checks that only the end-of-cycle offset yields an I/O cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef enum logic {
    SEL_CPU = 1'b0,
    SEL_IO  = 1'b1
  } sel_e;

  // Overlapped spacing holds only when no high-rate device forces burst mode.
  function automatic logic eff_overlap(input logic ovl, input logic burst);
    return ovl & ~burst;
  endfunction

  // A request is held back when spacing applies and the last branch was I/O.
  function automatic logic space_block(input logic ovl_eff, input logic prev_io);
    return ovl_eff & prev_io;
  endfunction

  // Exactly one strobe set in the phase vector.
  function automatic logic phase_legal(input logic [31:0] vec, input int unsigned n);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && vec[i]) cnt++;
    end
    return (cnt == 1);
  endfunction

endpackage

// File: rtl/csa_phase_tap.sv
module csa_phase_tap #(
  parameter int NPH     = 8,
  parameter int DEC_IDX = 0,
  parameter int BRN_IDX = 1,
  parameter int LST_IDX = NPH - 1
) (
  input  logic [NPH-1:0] phase_i,
  output logic           ph_decide,
  output logic           ph_branch,
  output logic           ph_last
);
  import csa_pkg::*;

  logic ph_ok;

  always_comb begin
    logic [31:0] wide;
    wide = '0;
    wide[NPH-1:0] = phase_i;
    ph_ok = phase_legal(wide, NPH);
  end

  assign ph_decide = ph_ok & phase_i[DEC_IDX];
  assign ph_branch = ph_ok & phase_i[BRN_IDX];
  assign ph_last   = ph_ok & phase_i[LST_IDX];

endmodule

// File: rtl/csa_req_gate.sv
module csa_req_gate #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req_i,
  input  logic            ph_last,
  output logic            req_lat
);
  logic [NSRC:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_req_i[g];
  end

  // Sampled only at the end-of-cycle phase: requests raised elsewhere wait.
  always_ff @(posedge clk) begin
    if (!rst_n)       req_lat <= 1'b0;
    else if (ph_last) req_lat <= chain[NSRC];
  end

endmodule

// File: rtl/csa_grant_sched.sv
module csa_grant_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_decide,
  input  logic ph_branch,
  input  logic req_lat,
  input  logic ovl_eff,
  output logic xfer_q,
  output logic gate_a,
  output logic gate_r
);
  import csa_pkg::*;

  sel_e take_io;
  logic last_io;

  assign xfer_q = req_lat & ~space_block(ovl_eff, last_io);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_io <= SEL_CPU;
      last_io <= 1'b0;
    end else begin
      if (ph_decide) take_io <= xfer_q ? SEL_IO : SEL_CPU;
      if (ph_branch) last_io <= (take_io == SEL_IO);
    end
  end

  assign gate_a = ph_branch & (take_io == SEL_CPU);
  assign gate_r = ph_branch & (take_io == SEL_IO);

endmodule

// File: rtl/csa_err_mon.sv
module csa_err_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic err_smp,
  input  logic gate_a,
  input  logic xfer_q,
  output logic inst_chk
);
  logic clash;

  assign clash = err_smp & gate_a & xfer_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     inst_chk <= 1'b0;
    else if (clash) inst_chk <= 1'b1;
  end

endmodule

// File: rtl/cyc_steal_arb.sv
module cyc_steal_arb #(
  parameter int NSRC = 4,
  parameter int NPH  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req_i,
  input  logic [NPH-1:0]  phase_i,
  input  logic            err_smp_i,
  input  logic            ovl_i,
  input  logic            burst_i,
  output logic            xfer_req_o,
  output logic            gate_a_o,
  output logic            gate_r_o,
  output logic            inst_chk_o
);
  import csa_pkg::*;

  localparam int DEC_IDX = 0;
  localparam int BRN_IDX = 1;
  localparam int LST_IDX = NPH - 1;

  logic ph_decide, ph_branch, ph_last;
  logic req_lat;
  logic ovl_eff;

  assign ovl_eff = eff_overlap(ovl_i, burst_i);

  csa_phase_tap #(
    .NPH(NPH), .DEC_IDX(DEC_IDX), .BRN_IDX(BRN_IDX), .LST_IDX(LST_IDX)
  ) u_tap (
    .phase_i  (phase_i),
    .ph_decide(ph_decide),
    .ph_branch(ph_branch),
    .ph_last  (ph_last)
  );

  csa_req_gate #(.NSRC(NSRC)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req_i(src_req_i),
    .ph_last  (ph_last),
    .req_lat  (req_lat)
  );

  csa_grant_sched u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_decide(ph_decide),
    .ph_branch(ph_branch),
    .req_lat  (req_lat),
    .ovl_eff  (ovl_eff),
    .xfer_q   (xfer_req_o),
    .gate_a   (gate_a_o),
    .gate_r   (gate_r_o)
  );

  csa_err_mon u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_smp (err_smp_i),
    .gate_a  (gate_a_o),
    .xfer_q  (xfer_req_o),
    .inst_chk(inst_chk_o)
  );

endmodule

// File: rtl/cyc_steal_arb_chk.sv
module cyc_steal_arb_chk #(
  parameter int NSRC = 4,
  parameter int NPH  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req_i,
  input logic [NPH-1:0]  phase_i,
  input logic            err_smp_i,
  input logic            ovl_eff,
  input logic            req_lat,
  input logic            xfer_req_o,
  input logic            gate_a_o,
  input logic            gate_r_o,
  input logic            inst_chk_o
);
  logic ok, c_dec, c_brn, c_lst;
  logic prev_io, ovl_at_dec;

  assign ok    = $onehot(phase_i);
  assign c_dec = ok & phase_i[0];
  assign c_brn = ok & phase_i[1];
  assign c_lst = ok & phase_i[NPH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_io    <= 1'b0;
      ovl_at_dec <= 1'b0;
    end else begin
      if (c_brn) prev_io <= gate_r_o;
      if (c_dec) ovl_at_dec <= ovl_eff;
    end
  end

  p_latch_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lst && (|src_req_i)) |=> req_lat);
  p_latch_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lst && !(|src_req_i)) |=> !req_lat);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !c_lst |=> $stable(req_lat));
  p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_brn |-> ($countones({gate_a_o, gate_r_o}) == 1));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !c_brn |-> (!gate_a_o && !gate_r_o));
  p_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_brn && prev_io && ovl_at_dec) |-> !gate_r_o);
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_smp_i && gate_a_o && xfer_req_o) |=> inst_chk_o);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inst_chk_o |=> inst_chk_o);

endmodule

bind cyc_steal_arb cyc_steal_arb_chk #(.NSRC(NSRC), .NPH(NPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req_i (src_req_i),
  .phase_i   (phase_i),
  .err_smp_i (err_smp_i),
  .ovl_eff   (ovl_eff),
  .req_lat   (req_lat),
  .xfer_req_o(xfer_req_o),
  .gate_a_o  (gate_a_o),
  .gate_r_o  (gate_r_o),
  .inst_chk_o(inst_chk_o)
);

// File: tb/cyc_steal_arb_bench.sv
module cyc_steal_arb_bench;
  localparam int NSRC = 4;
  localparam int NPH  = 8;
  localparam int LST  = NPH - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_req_i = '0;
  logic [NPH-1:0]  phase_i = 1;
  logic            err_smp_i = 1'b1;
  logic            ovl_i = 1'b1;
  logic            burst_i = 1'b0;
  logic            xfer_req_o, gate_a_o, gate_r_o, inst_chk_o;

  always #2 clk = ~clk;

  cyc_steal_arb #(.NSRC(NSRC), .NPH(NPH)) u_cyc_steal_arb (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .phase_i(phase_i),
    .err_smp_i(err_smp_i), .ovl_i(ovl_i), .burst_i(burst_i),
    .xfer_req_o(xfer_req_o), .gate_a_o(gate_a_o), .gate_r_o(gate_r_o),
    .inst_chk_o(inst_chk_o)
  );

  int tests = 0, fails = 0;
  int ph = 0;
  int gr_cnt = 0, ga_cnt = 0;
  bit finished = 0;

  // reference model state
  bit m_req, m_take, m_err;
  int brn;
  int hist[$];

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_req = 0; m_take = 0; m_err = 0; brn = 0;
    hist.delete();
  endtask

  task automatic tick_vec(input logic [NPH-1:0] vec, input bit adv);
    bit ok, pd, pb, pl, oe, blk, e_x, e_a, e_r;
    phase_i = vec;
    #1;
    ok = $onehot(vec);
    pd = ok && vec[0];
    pb = ok && vec[1];
    pl = ok && vec[LST];
    oe = ovl_i && !burst_i;
    blk = oe && (hist.size() > 0) && (hist[hist.size()-1] == brn);
    e_x = m_req && !blk;
    e_a = pb && !m_take;
    e_r = pb && m_take;
    check("R3 gate_a", int'(gate_a_o), int'(e_a));
    check("R3 gate_r", int'(gate_r_o), int'(e_r));
    check("R4 xfer_req", int'(xfer_req_o), int'(e_x));
    check("R7 inst_chk", int'(inst_chk_o), int'(m_err));
    if (gate_r_o === 1'b1) gr_cnt++;
    if (gate_a_o === 1'b1) ga_cnt++;
    if (err_smp_i && e_a && e_x) m_err = 1;
    if (pl) m_req = |src_req_i;
    if (pd) m_take = e_x;
    if (pb) begin
      brn++;
      if (m_take) hist.push_back(brn);
    end
    if (adv) ph = (ph + 1) % NPH;
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    logic [NPH-1:0] one;
    one = 1;
    tick_vec(one << ph, 1);
  endtask

  task automatic align();
    while (ph != 0) tick();
  endtask

  task automatic run_cycles(input int n);
    repeat (n * NPH) tick();
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    model_clear();
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8: cleared state, first branch picks processor
    check("R8 xfer after reset", int'(xfer_req_o), 0);
    check("R8 inst_chk after reset", int'(inst_chk_o), 0);
    align();
    ga_cnt = 0; gr_cnt = 0;
    run_cycles(1);
    check("R8 first branch gate_a", ga_cnt, 1);
    check("R8 first branch gate_r", gr_cnt, 0);

    // R1/R2: one-clock pulse at every phase offset, rotating sources
    for (int p = 0; p < NPH; p++) begin
      src_req_i = '0;
      align();
      run_cycles(2);
      repeat (p) tick();
      src_req_i[p % NSRC] = 1'b1;
      gr_cnt = 0;
      tick();
      src_req_i = '0;
      align();
      run_cycles(2);
      if (p == LST) check("R1 end-of-cycle pulse granted", gr_cnt, 1);
      else          check("R2 mid-cycle pulse ignored", gr_cnt, 0);
    end

    // R9: stalled and two-hot phase vectors at the end-of-cycle slot
    src_req_i = '0;
    align();
    run_cycles(2);
    repeat (LST) tick();
    src_req_i = 4'b0100;
    gr_cnt = 0;
    tick_vec('0, 0);
    tick_vec((NPH'(1) << LST) | NPH'(2), 0);
    src_req_i = '0;
    tick();
    run_cycles(2);
    check("R9 illegal phase vector ignored", gr_cnt, 0);

    // R5: overlapped, held request alternates
    ovl_i = 1; burst_i = 0;
    align();
    src_req_i = 4'b0010;
    gr_cnt = 0;
    run_cycles(12);
    check("R5 overlapped grants in 12 cycles", gr_cnt, 6);

    // R6: non-overlapped, every cycle
    ovl_i = 0;
    gr_cnt = 0;
    run_cycles(12);
    check("R6 non-overlapped grants in 12 cycles", gr_cnt, 12);

    // R6: burst device forces back-to-back even with overlap asked
    ovl_i = 1; burst_i = 1;
    gr_cnt = 0;
    run_cycles(12);
    check("R6 burst grants in 12 cycles", gr_cnt, 12);

    // R4: spacing blocks the leftover request after a grant
    burst_i = 0;
    src_req_i = '0;
    gr_cnt = 0;
    run_cycles(4);
    check("R4 blocked leftover request", gr_cnt, 0);
    check("R7 no false instruction check", int'(inst_chk_o), 0);

    // R7: revive the request between decision and branch
    src_req_i = 4'b1000;
    run_cycles(2);
    tick();          // decision phase, spacing blocks
    ovl_i = 0;       // request revives after the choice
    tick();          // branch: gate_a with live request
    ovl_i = 1;
    align();
    check("R7 clash raises instruction check", int'(inst_chk_o), 1);
    src_req_i = '0;
    run_cycles(3);
    check("R7 instruction check sticky", int'(inst_chk_o), 1);

    do_reset();
    check("R8 reset clears instruction check", int'(inst_chk_o), 0);
    check("R8 reset clears request", int'(xfer_req_o), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule